// File: doc/BRIEF.md
# Burst Gate and Horizontal Blanking Generator

This block runs on the line-locked pixel clock of a camera sync chain and turns each rising edge of the separated horizontal sync into two timing pulses. One is a horizontal blanking pulse that starts at the edge. The other is a burst gate pulse that opens a fixed delay later and closes a fixed width after that. The widths and delays come from the selected television standard and are expressed in clock cycles. The defaults assume 910 clocks per line for the 525-line standard and 282 clocks per line for the 625-line standard, and each value is rounded to the nearest cycle.

A line counter restarts on every vertical reset pulse and advances on each horizontal sync edge. The burst gate is produced only on the lines of a window counted from that reset. Both outputs are forced low while the external synchronisation mode is off. A horizontal sync edge that arrives while a pulse is still running restarts the pulse timing from the new edge.

Top module: `burst_blank_gen`

## Requirements
- R1: While rst_ni is low, blank_o and burst_o are low, the pulse timer is idle and the line count is zero.
- R2: A rising edge of hsync_i is sampled at a clock edge. The blanking pulse then goes high after that clock edge and stays high for BLANK cycles: 127 when ntsc_i=1 and 39 when ntsc_i=0.
- R3: The burst gate goes high DLY cycles after the blanking pulse rises and stays high for WID cycles. DLY/WID is 76/36 when ntsc_i=1 and 25/10 when ntsc_i=0.
- R4: Line n is the n-th hsync_i rising edge after the last vertical reset. The burst gate is produced only for lines 10 to 256 when ntsc_i=1, and for lines 10 to 304 when ntsc_i=0. The standard is taken at that line's edge.
- R5: The line count saturates one line past the longer window end and never wraps. After 620 lines with no vertical reset, no burst appears beyond the window.
- R6: vrst_i high at a clock edge sets the line count to zero. This takes priority over an hsync_i edge in the same cycle.
- R7: While ext_en_i is low, blank_o and burst_o are low. Line counting and pulse timing continue underneath.
- R8: An hsync_i rising edge that arrives during a running pulse restarts the timing from zero at that edge.
- R9: An hsync_i held high for many cycles triggers only once. A trigger needs a low-to-high transition.
- R10: ntsc_i selects between the two sets of cycle counts: 1 for the 525-line standard and 0 for the 625-line standard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Line-locked pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Separated horizontal sync; the rising edge starts a line |
| vrst_i | input | 1 | Vertical reset pulse; clears the line count |
| ntsc_i | input | 1 | Standard select: 1 = 525-line, 0 = 625-line |
| ext_en_i | input | 1 | External synchronisation enable; low forces the outputs low |
| blank_o | output | 1 | Horizontal blanking pulse |
| burst_o | output | 1 | Burst gate pulse |

## Verification
The assertions check the following on every cycle:
- the pulse timer restarts on each sync edge;
- both pulses rise only at the expected timer phase;
- a vertical reset clears the line count;
- the line count neither exceeds its saturation value nor leaves it;
- the burst gate stays inside the blanking pulse.

Some behaviours need whole scenarios, which the bench's reference model compares cycle by cycle. These are:
- the exact number of burst pulses per frame in each standard;
- the absence of a wrap-around after a long run without a vertical reset;
- the line count surviving a period with the outputs disabled;
- the lengthened blanking on retrigger.

// File: rtl/burst_blank_pkg.sv
package burst_blank_pkg;

  typedef enum logic {
    STD_625 = 1'b0,
    STD_525 = 1'b1
  } video_std_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bbg_edge_det.sv
module bbg_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  output logic start_o
);

  logic hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hs_q <= 1'b0;
    else         hs_q <= hsync_i;
  end

  assign start_o = hsync_i & ~hs_q;

  // a level held high cannot retrigger
  p_single_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

endmodule

// File: rtl/bbg_line_win.sv
module bbg_line_win
  import burst_blank_pkg::*;
#(
  parameter int unsigned FIRST  = 10,
  parameter int unsigned N_LAST = 256,
  parameter int unsigned P_LAST = 304,
  parameter int unsigned SAT    = max2(N_LAST, P_LAST) + 1,
  parameter int unsigned LN_W   = $clog2(SAT + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vrst_i,
  input  logic       start_i,
  input  video_std_e std_i,
  output logic       win_o
);

  localparam logic [LN_W-1:0] FIRST_C = LN_W'(FIRST);
  localparam logic [LN_W-1:0] NLAST_C = LN_W'(N_LAST);
  localparam logic [LN_W-1:0] PLAST_C = LN_W'(P_LAST);
  localparam logic [LN_W-1:0] SAT_C   = LN_W'(SAT);

  logic [LN_W-1:0] cnt_q, cnt_d;
  logic [LN_W-1:0] last_w;
  logic            win_q, win_d;

  assign last_w = (std_i == STD_525) ? NLAST_C : PLAST_C;

  always_comb begin
    cnt_d = cnt_q;
    if (vrst_i)                       cnt_d = '0;
    else if (start_i && cnt_q != SAT_C) cnt_d = cnt_q + 1'b1;
  end

  // window decision latched per line from the new count
  always_comb begin
    win_d = win_q;
    if (start_i) win_d = (cnt_d >= FIRST_C) && (cnt_d <= last_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      win_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      win_q <= win_d;
    end
  end

  assign win_o = win_q;

  p_vr_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vrst_i |=> (cnt_q == '0));

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SAT_C);

  p_sat_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == SAT_C && !vrst_i) |=> (cnt_q == SAT_C));

endmodule

// File: rtl/bbg_pulse_timer.sv
module bbg_pulse_timer
  import burst_blank_pkg::*;
#(
  parameter int unsigned N_BLANK = 127,
  parameter int unsigned N_DLY   = 76,
  parameter int unsigned N_WID   = 36,
  parameter int unsigned P_BLANK = 39,
  parameter int unsigned P_DLY   = 25,
  parameter int unsigned P_WID   = 10,
  parameter int unsigned PH_MAX  = max2(max2(N_BLANK, N_DLY + N_WID),
                                        max2(P_BLANK, P_DLY + P_WID)),
  parameter int unsigned PH_W    = $clog2(PH_MAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  video_std_e std_i,
  input  logic       win_i,
  output logic       blank_raw_o,
  output logic       burst_raw_o
);

  localparam logic [PH_W-1:0] NB_C   = PH_W'(N_BLANK);
  localparam logic [PH_W-1:0] ND_C   = PH_W'(N_DLY);
  localparam logic [PH_W-1:0] NE_C   = PH_W'(N_DLY + N_WID);
  localparam logic [PH_W-1:0] PB_C   = PH_W'(P_BLANK);
  localparam logic [PH_W-1:0] PD_C   = PH_W'(P_DLY);
  localparam logic [PH_W-1:0] PE_C   = PH_W'(P_DLY + P_WID);
  localparam logic [PH_W-1:0] IDLE_C = PH_W'(PH_MAX);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] blank_len, dly_c, end_c;

  always_comb begin
    if (std_i == STD_525) begin
      blank_len = NB_C;
      dly_c     = ND_C;
      end_c     = NE_C;
    end else begin
      blank_len = PB_C;
      dly_c     = PD_C;
      end_c     = PE_C;
    end
  end

  // phase saturates at IDLE_C, beyond every pulse end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ph_q <= IDLE_C;
    else if (start_i)         ph_q <= '0;
    else if (ph_q != IDLE_C)  ph_q <= ph_q + 1'b1;
  end

  assign blank_raw_o = (ph_q < blank_len);
  assign burst_raw_o = win_i && (ph_q >= dly_c) && (ph_q < end_c);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ph_q == '0));

  p_blank_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(blank_raw_o) && $stable(std_i)) |-> (ph_q == '0));

  p_burst_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(burst_raw_o) && $stable(std_i)) |-> (ph_q == dly_c));

endmodule

// File: rtl/burst_blank_gen.sv
module burst_blank_gen
  import burst_blank_pkg::*;
#(
  parameter int unsigned N_BLANK = 127,
  parameter int unsigned N_DLY   = 76,
  parameter int unsigned N_WID   = 36,
  parameter int unsigned P_BLANK = 39,
  parameter int unsigned P_DLY   = 25,
  parameter int unsigned P_WID   = 10,
  parameter int unsigned FIRST   = 10,
  parameter int unsigned N_LAST  = 256,
  parameter int unsigned P_LAST  = 304
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vrst_i,
  input  logic ntsc_i,
  input  logic ext_en_i,
  output logic blank_o,
  output logic burst_o
);

  localparam int unsigned PH_MAX = max2(max2(N_BLANK, N_DLY + N_WID),
                                        max2(P_BLANK, P_DLY + P_WID));
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
  localparam int unsigned SAT    = max2(N_LAST, P_LAST) + 1;
  localparam int unsigned LN_W   = $clog2(SAT + 1);
  localparam bit NESTED = (N_DLY + N_WID <= N_BLANK) && (P_DLY + P_WID <= P_BLANK);

  video_std_e std_w;
  logic       start_w, win_w, blank_raw_w, burst_raw_w;

  assign std_w = video_std_e'(ntsc_i);

  bbg_edge_det i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hsync_i (hsync_i),
    .start_o (start_w)
  );

  bbg_line_win #(
    .FIRST  (FIRST),
    .N_LAST (N_LAST),
    .P_LAST (P_LAST),
    .SAT    (SAT),
    .LN_W   (LN_W)
  ) i_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vrst_i  (vrst_i),
    .start_i (start_w),
    .std_i   (std_w),
    .win_o   (win_w)
  );

  bbg_pulse_timer #(
    .N_BLANK (N_BLANK),
    .N_DLY   (N_DLY),
    .N_WID   (N_WID),
    .P_BLANK (P_BLANK),
    .P_DLY   (P_DLY),
    .P_WID   (P_WID),
    .PH_MAX  (PH_MAX),
    .PH_W    (PH_W)
  ) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_w),
    .std_i       (std_w),
    .win_i       (win_w),
    .blank_raw_o (blank_raw_w),
    .burst_raw_o (burst_raw_w)
  );

  assign blank_o = ext_en_i & blank_raw_w;
  assign burst_o = ext_en_i & burst_raw_w;

  generate
    if (NESTED) begin : g_nest_chk
      p_burst_in_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        burst_o |-> blank_o);
    end
  endgenerate

endmodule

// File: tb/test_burst_blank_gen.sv
module test_burst_blank_gen;

  localparam int CLK_P  = 10;
  localparam int BIG    = 100000;
  localparam int HS_HI  = 4;
  localparam int SAT    = 305;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, vrst = 1'b0, ntsc = 1'b1, ext_en = 1'b1;
  logic blank, burst;

  int vectors = 0, errors = 0;
  int n_blank = 0, n_burst = 0;
  logic bu_prev = 1'b0;
  bit done = 1'b0;

  // reference model state
  int  m_ph = BIG, m_line = 0;
  bit  m_win = 1'b0, m_hs = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  burst_blank_gen i_burst_blank_gen (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .hsync_i  (hsync),
    .vrst_i   (vrst),
    .ntsc_i   (ntsc),
    .ext_en_i (ext_en),
    .blank_o  (blank),
    .burst_o  (burst)
  );

  function automatic int blen(bit n);   return n ? 127 : 39; endfunction
  function automatic int bdly(bit n);   return n ? 76 : 25;  endfunction
  function automatic int bwid(bit n);   return n ? 36 : 10;  endfunction
  function automatic int wlast(bit n);  return n ? 256 : 304; endfunction

  always @(posedge clk) begin
    bit e_blank, e_burst, edge_b;
    if (!rst_n) begin
      m_ph = BIG; m_line = 0; m_win = 1'b0; m_hs = 1'b0;
    end else begin
      edge_b = hsync && !m_hs;
      m_hs = hsync;
      if (vrst) m_line = 0;
      else if (edge_b && m_line < SAT) m_line++;
      if (edge_b) begin
        m_ph = 0;
        m_win = (m_line >= 10) && (m_line <= wlast(ntsc));
      end else if (m_ph < BIG) m_ph++;
    end
    #(CLK_P/4);
    e_blank = ext_en && (m_ph < blen(ntsc));
    e_burst = ext_en && m_win && (m_ph >= bdly(ntsc)) && (m_ph < bdly(ntsc) + bwid(ntsc));
    vectors++;
    if (blank !== e_blank || burst !== e_burst) begin
      errors++;
      if (blank !== e_blank)
        $display("FAIL R2 blank_o got %b exp %b at %0t", blank, e_blank, $time);
      else
        $display("FAIL R3 burst_o got %b exp %b at %0t", burst, e_burst, $time);
    end
    if (blank === 1'b1) n_blank++;
    if (burst === 1'b1 && !bu_prev) n_burst++;
    bu_prev = burst;
  end

  task automatic check(string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk);
    n_blank = 0; n_burst = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk) hsync = 1'b0;
  endtask

  task automatic lines(int n, int per);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) hsync = 1'b1;
      repeat (HS_HI - 1) @(negedge clk);
      hsync = 1'b0;
      repeat (per - HS_HI) @(negedge clk);
    end
  endtask

  task automatic vr_pulse();
    @(negedge clk) vrst = 1'b1;
    @(negedge clk) vrst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog expired got running exp done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 blank in reset", int'(blank), 0);
    check("R1 burst in reset", int'(burst), 0);
    rst_n = 1'b1;
    idle(10);

    // R4 R10: 525-line frame window
    ntsc = 1'b1;
    vr_pulse();
    clr();
    lines(320, 140);
    idle(5);
    check("R4 525 burst count", n_burst, 247);
    check("R10 525 blank cycles", n_blank, 320 * 127);

    // R5 R10: 625-line long run, no wrap
    ntsc = 1'b0;
    idle(5);
    vr_pulse();
    clr();
    lines(620, 50);
    idle(5);
    check("R5 625 burst count no wrap", n_burst, 295);
    check("R10 625 blank cycles", n_blank, 620 * 39);

    // R6: vertical reset restarts the line count
    ntsc = 1'b1;
    idle(5);
    vr_pulse();
    lines(5, 140);
    vr_pulse();
    clr();
    lines(9, 140);
    check("R6 no burst before line 10", n_burst, 0);
    clr();
    lines(1, 140);
    check("R6 burst on line 10", n_burst, 1);

    // R7: disable hides outputs, counting goes on
    ext_en = 1'b0;
    clr();
    lines(20, 140);
    check("R7 blank while disabled", n_blank, 0);
    check("R7 burst while disabled", n_burst, 0);
    ext_en = 1'b1;
    clr();
    lines(1, 140);
    check("R7 burst after enable", n_burst, 1);

    // R8: retrigger during blanking
    clr();
    lines(1, 50);
    lines(1, 140);
    idle(10);
    check("R8 retrigger blank cycles", n_blank, 50 + 127);
    check("R8 retrigger burst count", n_burst, 1);

    // R9: long high level triggers once
    clr();
    @(negedge clk) hsync = 1'b1;
    repeat (400) @(negedge clk);
    hsync = 1'b0;
    idle(200);
    check("R9 held-high blank cycles", n_blank, 127);
    check("R9 held-high burst count", n_burst, 1);

    // R3 R2: vr and edge together in 625 mode
    ntsc = 1'b0;
    idle(5);
    @(negedge clk) begin vrst = 1'b1; hsync = 1'b1; end
    @(negedge clk) vrst = 1'b0;
    clr();
    idle(80);
    check("R6 vr wins over edge", n_burst, 0);

    idle(5);
    finish_run();
  end

endmodule